// File: doc/BRIEF.md
# Sub-Thread Speculative Dependence Tracker

This block keeps the shared-cache metadata that catches read-after-write dependence violations between speculative threads at the moment they happen. Each thread is cut into sub-thread checkpoints. For every tracked line the block keeps one speculative-load bit and one speculative-store bit per sub-thread of every thread. A store from a thread is compared at once against the load bits of all logically later threads. If one of them has already read the line, the block names that thread and the earliest sub-thread that must restart. The sub-threads before that checkpoint keep their work.

Thread order is a ring that starts at the current oldest thread, which is thread 0 after reset. A commit retires the oldest thread, clears all of its bits and moves the oldest position to the next thread id. A rewind command clears one thread's bits from a given sub-thread onward. Both commands walk the line array one line per cycle. Every accepted access returns a one-cycle response one cycle later. The response gives the single per-line dirty bit the private cache keeps, which has no sub-thread detail, and tells whether the line now holds stores from more than one thread and so needs more than one version.

The controller has two states. In `ST_ACTIVE` it accepts requests. An accepted commit or rewind moves it to `ST_CLEAR`. In `ST_CLEAR` it clears the selected bits on one line per cycle, and it returns to `ST_ACTIVE` after the last line.

Top module: `subthread_dep_tracker`

## Requirements
- R1: After reset, busy, viol_valid and resp_valid are 0 and oldest_thread is 0.
- R2: A store accepted at clock edge E from a thread that is earlier in ring order than another thread, to a line on which that later thread has a recorded load, sets viol_valid for exactly the cycle after E. In that cycle viol_thread holds the later thread's id.
- R3: No violation is raised when the only recorded loads on the line belong to the storing thread or to threads earlier than it, or sit on other lines.
- R4: viol_sub is the lowest-numbered sub-thread of the violated thread that has a load recorded on that line.
- R5: A load is not recorded when any sub-thread of the same thread has already stored to the line. A later store by an earlier thread then raises no violation for it.
- R6: resp_valid is 1 for exactly the cycle after each accepted access. resp_own_dirty then shows whether the accessing thread, in any sub-thread, holds a store on that line, this access included.
- R7: resp_multi is 1 when, after the access, stores from two or more distinct threads are recorded on the line.
- R8: A rewind of thread T from sub-thread S clears the load and store bits of T's sub-threads S and above on every line. Bits of T's lower sub-threads and of other threads stay.
- R9: A commit clears every bit of the current oldest thread and advances oldest_thread by one, modulo THREADS. Ring order for later checks starts from the new oldest.
- R10: A command drives busy high for exactly LINES cycles, starting the cycle after it is accepted. Accesses and commands presented while busy is high are ignored.
- R11: When the block is idle and requests arrive in the same cycle, commit takes precedence over rewind, and rewind takes precedence over access. Only one request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_thread | input | log2(THREADS) | Thread issuing the access |
| req_sub | input | log2(SUBS) | Sub-thread issuing the access |
| req_line | input | log2(LINES) | Line index |
| req_store | input | 1 | 1 = store, 0 = load |
| commit_req | input | 1 | Retire the oldest thread |
| rewind_req | input | 1 | Roll back a thread from a sub-thread onward |
| rewind_thread | input | log2(THREADS) | Thread to roll back |
| rewind_sub | input | log2(SUBS) | First sub-thread to discard |
| busy | output | 1 | Line sweep in progress |
| oldest_thread | output | log2(THREADS) | Current head of thread order |
| resp_valid | output | 1 | Access response strobe |
| resp_own_dirty | output | 1 | Accessing thread holds a store on the line |
| resp_multi | output | 1 | Line holds stores from several threads |
| viol_valid | output | 1 | Dependence violation pulse |
| viol_thread | output | log2(THREADS) | Thread that must roll back |
| viol_sub | output | log2(SUBS) | Earliest sub-thread to restart |

## Verification
The bench first loads both sub-threads of the younger thread on one line and checks that a store reports sub-thread 0. A design that picks the highest set bit would name the wrong checkpoint. It then rewinds from sub-thread 1 and checks that the surviving sub-thread 0 load still raises a violation while a line read only by sub-thread 1 stays quiet. A design that clears the whole thread, or clears nothing, fails one of the two. It tests a read after the thread's own store, a load and a second commit presented during a sweep, and a cycle that carries all three requests at once. After a commit it checks that order is taken from the new oldest thread, so a store by thread 1 violates thread 0. A design with a fixed thread order would miss that violation.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
    typedef enum logic [0:0] {
        ST_ACTIVE = 1'b0,
        ST_CLEAR  = 1'b1
    } trk_state_e;
endpackage

// File: rtl/sdt_ctrl_fsm.sv
module sdt_ctrl_fsm
    import sdt_pkg::*;
#(
    parameter int LINES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    output logic                     busy,
    output logic                     sweep_en,
    output logic [$clog2(LINES)-1:0] sweep_line
);
    localparam int LW = $clog2(LINES);
    localparam logic [LW-1:0] LAST = LW'(LINES - 1);

    trk_state_e state_q, state_d;
    logic [LW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: if (start) state_d = ST_CLEAR;
            ST_CLEAR:  if (cnt_q == LAST) state_d = ST_ACTIVE;
            default:   state_d = ST_ACTIVE;
        endcase
    end

    // sweep position
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (state_q == ST_CLEAR) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        else                         cnt_q <= '0;
    end

    // outputs
    always_comb begin
        busy       = 1'b0;
        sweep_en   = 1'b0;
        sweep_line = cnt_q;
        unique case (state_q)
            ST_ACTIVE: begin busy = 1'b0; sweep_en = 1'b0; end
            ST_CLEAR:  begin busy = 1'b1; sweep_en = 1'b1; end
            default:   begin busy = 1'b0; sweep_en = 1'b0; end
        endcase
    end
endmodule

// File: rtl/sdt_conflict_scan.sv
module sdt_conflict_scan #(
    parameter int THREADS = 2,
    parameter int SUBS    = 2
) (
    input  logic [THREADS*SUBS-1:0]    ld_row,
    input  logic [THREADS*SUBS-1:0]    st_row,
    input  logic [$clog2(THREADS)-1:0] who,
    input  logic [$clog2(THREADS)-1:0] oldest,
    output logic                       hit,
    output logic [$clog2(THREADS)-1:0] hit_thread,
    output logic [$clog2(SUBS)-1:0]    hit_sub,
    output logic                       own_store,
    output logic [THREADS-1:0]         store_threads
);
    localparam int TW = $clog2(THREADS);
    localparam int SW = $clog2(SUBS);

    function automatic logic [TW-1:0] rank_of(input logic [TW-1:0] t, input logic [TW-1:0] o);
        return t - o;
    endfunction

    for (genvar g = 0; g < THREADS; g++) begin : g_writers
        assign store_threads[g] = |st_row[g*SUBS +: SUBS];
    end

    assign own_store = store_threads[who];

    logic [TW-1:0] best_rank;
    logic [TW-1:0] who_rank;
    logic [SW-1:0] low_sub;

    always_comb begin
        hit        = 1'b0;
        hit_thread = '0;
        hit_sub    = '0;
        best_rank  = '1;
        low_sub    = '0;
        who_rank   = rank_of(who, oldest);
        for (int t = 0; t < THREADS; t++) begin
            low_sub = '0;
            for (int s = SUBS - 1; s >= 0; s--) begin
                if (ld_row[t*SUBS + s]) low_sub = SW'(s);
            end
            if ((rank_of(TW'(t), oldest) > who_rank) && (|ld_row[t*SUBS +: SUBS]) &&
                (!hit || (rank_of(TW'(t), oldest) < best_rank))) begin
                hit        = 1'b1;
                hit_thread = TW'(t);
                hit_sub    = low_sub;
                best_rank  = rank_of(TW'(t), oldest);
            end
        end
    end
endmodule

// File: rtl/subthread_dep_tracker.sv
module subthread_dep_tracker
    import sdt_pkg::*;
#(
    parameter int THREADS = 2,
    parameter int SUBS    = 2,
    parameter int LINES   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [$clog2(THREADS)-1:0] req_thread,
    input  logic [$clog2(SUBS)-1:0]    req_sub,
    input  logic [$clog2(LINES)-1:0]   req_line,
    input  logic                       req_store,
    input  logic                       commit_req,
    input  logic                       rewind_req,
    input  logic [$clog2(THREADS)-1:0] rewind_thread,
    input  logic [$clog2(SUBS)-1:0]    rewind_sub,
    output logic                       busy,
    output logic [$clog2(THREADS)-1:0] oldest_thread,
    output logic                       resp_valid,
    output logic                       resp_own_dirty,
    output logic                       resp_multi,
    output logic                       viol_valid,
    output logic [$clog2(THREADS)-1:0] viol_thread,
    output logic [$clog2(SUBS)-1:0]    viol_sub
);
    localparam int TW  = $clog2(THREADS);
    localparam int SW  = $clog2(SUBS);
    localparam int LW  = $clog2(LINES);
    localparam int CTX = THREADS * SUBS;
    localparam int CW  = $clog2(CTX);

    logic [CTX-1:0] ld_q [LINES];
    logic [CTX-1:0] st_q [LINES];
    logic [CTX-1:0] clr_mask_q, clr_mask_d;
    logic [TW-1:0]  oldest_q;

    logic          sweep_en;
    logic [LW-1:0] sweep_line;
    logic          cmd_commit, cmd_rewind, acc_go, start;
    logic [CW-1:0] acc_ctx;

    logic               hit, own_store;
    logic [TW-1:0]      hit_thread;
    logic [SW-1:0]      hit_sub;
    logic [THREADS-1:0] store_threads, writers_after;

    // request arbitration: commit, then rewind, then access
    assign cmd_commit = commit_req & ~busy;
    assign cmd_rewind = rewind_req & ~busy & ~commit_req;
    assign acc_go     = req_valid  & ~busy & ~commit_req & ~rewind_req;
    assign start      = cmd_commit | cmd_rewind;
    assign acc_ctx    = CW'(int'(req_thread) * SUBS + int'(req_sub));

    sdt_ctrl_fsm #(.LINES(LINES)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .busy       (busy),
        .sweep_en   (sweep_en),
        .sweep_line (sweep_line)
    );

    sdt_conflict_scan #(.THREADS(THREADS), .SUBS(SUBS)) scan_i (
        .ld_row        (ld_q[req_line]),
        .st_row        (st_q[req_line]),
        .who           (req_thread),
        .oldest        (oldest_q),
        .hit           (hit),
        .hit_thread    (hit_thread),
        .hit_sub       (hit_sub),
        .own_store     (own_store),
        .store_threads (store_threads)
    );

    // which context bits the coming sweep removes
    always_comb begin
        clr_mask_d = '0;
        for (int k = 0; k < CTX; k++) begin
            if (commit_req)
                clr_mask_d[k] = (TW'(k / SUBS) == oldest_q);
            else
                clr_mask_d[k] = (TW'(k / SUBS) == rewind_thread) && (SW'(k % SUBS) >= rewind_sub);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     clr_mask_q <= '0;
        else if (start) clr_mask_q <= clr_mask_d;
    end

    // per-line speculative load/store bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                ld_q[i] <= '0;
                st_q[i] <= '0;
            end
        end else begin
            if (sweep_en) begin
                ld_q[sweep_line] <= ld_q[sweep_line] & ~clr_mask_q;
                st_q[sweep_line] <= st_q[sweep_line] & ~clr_mask_q;
            end
            if (acc_go) begin
                if (req_store)       st_q[req_line][acc_ctx] <= 1'b1;
                else if (!own_store) ld_q[req_line][acc_ctx] <= 1'b1;
            end
        end
    end

    assign writers_after = store_threads | (req_store ? (THREADS'(1) << req_thread) : '0);

    // registered responses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oldest_q       <= '0;
            resp_valid     <= 1'b0;
            resp_own_dirty <= 1'b0;
            resp_multi     <= 1'b0;
            viol_valid     <= 1'b0;
            viol_thread    <= '0;
            viol_sub       <= '0;
        end else begin
            if (cmd_commit) oldest_q <= oldest_q + 1'b1;
            resp_valid     <= acc_go;
            resp_own_dirty <= acc_go & (req_store | own_store);
            resp_multi     <= acc_go & ($countones(writers_after) > 1);
            viol_valid     <= acc_go & req_store & hit;
            if (acc_go & req_store & hit) begin
                viol_thread <= hit_thread;
                viol_sub    <= hit_sub;
            end
        end
    end

    assign oldest_thread = oldest_q;
endmodule

// File: rtl/sdt_tracker_chk.sv
module sdt_tracker_chk #(
    parameter int THREADS = 2,
    parameter int SUBS    = 2,
    parameter int LINES   = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic [$clog2(THREADS)-1:0] req_thread,
    input logic                       req_store,
    input logic                       commit_req,
    input logic                       rewind_req,
    input logic                       busy,
    input logic [$clog2(THREADS)-1:0] oldest_thread,
    input logic                       resp_valid,
    input logic                       viol_valid,
    input logic [$clog2(THREADS)-1:0] viol_thread
);
    int unsigned busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    // R2
    viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> $past(req_valid && req_store && !busy && !commit_req && !rewind_req));

    // R3
    viol_later_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> (viol_thread != $past(req_thread)));

    // R9
    oldest_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oldest_thread != $past(oldest_thread)) |-> $past(commit_req && !busy));

    // R10
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit_req || rewind_req));

    // R10
    busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= LINES);

    // R10
    resp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !resp_valid);
endmodule

bind subthread_dep_tracker sdt_tracker_chk #(
    .THREADS (THREADS),
    .SUBS    (SUBS),
    .LINES   (LINES)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_thread    (req_thread),
    .req_store     (req_store),
    .commit_req    (commit_req),
    .rewind_req    (rewind_req),
    .busy          (busy),
    .oldest_thread (oldest_thread),
    .resp_valid    (resp_valid),
    .viol_valid    (viol_valid),
    .viol_thread   (viol_thread)
);

// File: tb/subthread_dep_tracker_tb_top.sv
module subthread_dep_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int THREADS = 2;
    localparam int SUBS    = 2;
    localparam int LINES   = 16;
    localparam int TW = $clog2(THREADS);
    localparam int SW = $clog2(SUBS);
    localparam int LW = $clog2(LINES);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [TW-1:0] req_thread = '0;
    logic [SW-1:0] req_sub = '0;
    logic [LW-1:0] req_line = '0;
    logic          req_store = 1'b0;
    logic          commit_req = 1'b0;
    logic          rewind_req = 1'b0;
    logic [TW-1:0] rewind_thread = '0;
    logic [SW-1:0] rewind_sub = '0;
    logic          busy, resp_valid, resp_own_dirty, resp_multi, viol_valid;
    logic [TW-1:0] oldest_thread, viol_thread;
    logic [SW-1:0] viol_sub;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    typedef struct {
        bit    viol;
        int    th;
        int    sb;
        bit    own;
        bit    multi;
        string rq;
    } exp_t;
    exp_t sbq[$];
    exp_t cur;

    always #(CLK_PERIOD / 2) clk = ~clk;

    subthread_dep_tracker #(.THREADS(THREADS), .SUBS(SUBS), .LINES(LINES)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_thread     (req_thread),
        .req_sub        (req_sub),
        .req_line       (req_line),
        .req_store      (req_store),
        .commit_req     (commit_req),
        .rewind_req     (rewind_req),
        .rewind_thread  (rewind_thread),
        .rewind_sub     (rewind_sub),
        .busy           (busy),
        .oldest_thread  (oldest_thread),
        .resp_valid     (resp_valid),
        .resp_own_dirty (resp_own_dirty),
        .resp_multi     (resp_multi),
        .viol_valid     (viol_valid),
        .viol_thread    (viol_thread),
        .viol_sub       (viol_sub)
    );

    task automatic chk(input string rq, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // driver: one access, expected response queued for the monitor
    task automatic access(input int th, input int sb, input int ln, input bit st,
                          input bit ev, input int et, input int es,
                          input bit eown, input bit emulti, input string rq);
        exp_t e;
        @(negedge clk);
        req_valid  = 1'b1;
        req_thread = TW'(th);
        req_sub    = SW'(sb);
        req_line   = LW'(ln);
        req_store  = st;
        e.viol = ev; e.th = et; e.sb = es; e.own = eown; e.multi = emulti; e.rq = rq;
        sbq.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // pulse a command for one cycle; returns at the negedge after acceptance
    task automatic command(input bit c, input bit r, input int th, input int sb);
        @(negedge clk);
        commit_req    = c;
        rewind_req    = r;
        rewind_thread = TW'(th);
        rewind_sub    = SW'(sb);
        @(negedge clk);
        commit_req = 1'b0;
        rewind_req = 1'b0;
    endtask

    task automatic wait_idle(input string rq, input int exp_cycles);
        int n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk(rq, n, exp_cycles);
    endtask

    // monitor: pop and compare on every response
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (resp_valid) begin
                if (sbq.size() == 0) begin
                    chk("R10 response with nothing expected", 1, 0);
                end else begin
                    cur = sbq.pop_front();
                    chk({cur.rq, " viol_valid"}, int'(viol_valid), int'(cur.viol));
                    if (cur.viol) begin
                        chk({cur.rq, " viol_thread"}, int'(viol_thread), cur.th);
                        chk({cur.rq, " viol_sub"}, int'(viol_sub), cur.sb);
                    end
                    chk({cur.rq, " resp_own_dirty"}, int'(resp_own_dirty), int'(cur.own));
                    chk({cur.rq, " resp_multi"}, int'(resp_multi), int'(cur.multi));
                end
            end else if (viol_valid) begin
                chk("R2 violation without response", 1, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 viol_valid", int'(viol_valid), 0);
        chk("R1 resp_valid", int'(resp_valid), 0);
        chk("R1 oldest_thread", int'(oldest_thread), 0);

        // R2 basic violation
        access(1, 0, 3, 0, 0, 0, 0, 0, 0, "R6 load t1s0 l3");
        access(0, 0, 3, 1, 1, 1, 0, 1, 0, "R2 store t0 l3");
        // R4 earliest sub-thread
        access(1, 1, 4, 0, 0, 0, 0, 0, 0, "R6 load t1s1 l4");
        access(0, 1, 4, 1, 1, 1, 1, 1, 0, "R4 store t0 l4 only s1");
        access(1, 0, 4, 0, 0, 0, 0, 0, 0, "R6 load t1s0 l4");
        access(0, 0, 4, 1, 1, 1, 0, 1, 0, "R4 store t0 l4 s0 and s1");
        // R3 no violation cases
        access(0, 0, 6, 0, 0, 0, 0, 0, 0, "R3 load t0 l6");
        access(1, 0, 6, 1, 0, 0, 0, 1, 0, "R3 later thread stores");
        access(1, 0, 8, 0, 0, 0, 0, 0, 0, "R3 load t1 l8");
        access(0, 0, 2, 1, 0, 0, 0, 1, 0, "R3 other line");
        // R7 two writers
        access(1, 0, 3, 1, 0, 0, 0, 1, 1, "R7 second writer l3");
        access(0, 1, 3, 0, 0, 0, 0, 1, 1, "R5 load after own store t0 l3");
        // R5 own-store load not recorded
        access(1, 0, 7, 1, 0, 0, 0, 1, 0, "R5 store t1s0 l7");
        access(1, 1, 7, 0, 0, 0, 0, 1, 0, "R5 load t1s1 l7");
        access(0, 0, 7, 1, 0, 0, 0, 1, 1, "R5 store t0 l7");
        access(1, 1, 10, 0, 0, 0, 0, 0, 0, "R8 load t1s1 l10");

        // R8 rewind t1 from s1, with an ignored load while busy (R10)
        command(0, 1, 1, 1);
        chk("R10 busy after rewind", int'(busy), 1);
        req_valid = 1'b1; req_thread = 1'b1; req_sub = 1'b1; req_line = LW'(9); req_store = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle("R10 rewind sweep length", LINES - 1);
        access(0, 0, 4, 1, 1, 1, 0, 1, 0, "R8 s0 load kept l4");
        access(0, 0, 10, 1, 0, 0, 0, 1, 0, "R8 s1 load cleared l10");
        access(0, 0, 9, 1, 0, 0, 0, 1, 0, "R10 load during busy ignored");

        // R8 rewind whole t1
        command(0, 1, 1, 0);
        wait_idle("R10 rewind sweep length", LINES);
        access(0, 0, 3, 1, 0, 0, 0, 1, 0, "R8 t1 bits cleared l3");

        // R9 commit, with an ignored second commit while busy (R10)
        access(0, 0, 12, 0, 0, 0, 0, 0, 0, "R9 load t0 l12");
        command(1, 0, 0, 0);
        commit_req = 1'b1;
        @(negedge clk);
        commit_req = 1'b0;
        wait_idle("R10 commit sweep length", LINES - 1);
        chk("R9 oldest advanced once", int'(oldest_thread), 1);
        access(1, 0, 12, 1, 0, 0, 0, 1, 0, "R9 t0 loads cleared l12");
        access(1, 0, 3, 1, 0, 0, 0, 1, 0, "R9 t0 stores cleared l3");
        access(0, 1, 13, 0, 0, 0, 0, 0, 0, "R9 load t0s1 l13");
        access(1, 0, 13, 1, 1, 0, 1, 1, 0, "R9 new order t1 before t0");

        // R11 all requests at once
        @(negedge clk);
        commit_req = 1'b1; rewind_req = 1'b1; rewind_thread = '0; rewind_sub = '0;
        req_valid = 1'b1; req_thread = 1'b1; req_sub = '0; req_line = LW'(14); req_store = 1'b0;
        @(negedge clk);
        commit_req = 1'b0; rewind_req = 1'b0; req_valid = 1'b0;
        chk("R11 commit accepted busy", int'(busy), 1);
        wait_idle("R11 commit sweep length", LINES);
        chk("R11 oldest wrapped", int'(oldest_thread), 0);

        repeat (3) @(negedge clk);
        chk("R6 all responses seen", sbq.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule